// File: doc/BRIEF.md
# Bit-Parallel Stuck-At Fault Simulator

This block grades a test set against single stuck-at faults on a small, fixed combinational netlist. It keeps every line of the netlist as a word of `LANES` bits. Each bit position, or lane, is one copy of the circuit. Lane 0 is always the fault-free copy. Every other lane carries one injected fault. A single bitwise AND, OR or NOT over the line words evaluates every copy at once. A fault is injected through per-line set and clear masks. These masks are applied where the line sits in the levelized order, so every gate downstream sees the forced value.

The netlist has three primary inputs, which drive lines 0 to 2 (test vector bit i drives line i). The gates are:
- line 3 = line0 AND line1
- line 4 = NOT line2
- line 5 = line3 OR line4
- line 6 = line1 OR line2
- line 7 = line5 AND line6

Lines 5 and 7 are the primary outputs. The faults are taken in groups of `LANES-1`. One pass over the whole test set is made for each group. The pass flags every lane whose output differs from lane 0, and it adds newly found faults to a running coverage count.

Top module: `bitpar_fault_sim`

## Requirements
- R1: After reset, `laneDet`, `detCount` and `done` are all 0.
- R2: Lane 0 is fault-free and `laneDet[0]` is never 1.
- R3: Fault table entry f occupies `faultTable[4f+3:4f]`. Bits [3:1] hold the line index and bit 0 holds the stuck value. Stuck-at-v forces that line to v only in the lane that carries the fault.
- R4: Pass p (p = 0..5) loads fault p*(LANES-1)+l-1 into lane l, for l = 1..LANES-1. There are ceil(NUM_FAULTS/(LANES-1)) passes.
- R5: At the end of a pass, bit l of `laneDet` is 1 exactly when either primary output (line 5 or 7) in lane l differed from lane 0 for at least one vector of the test set. The flags are cleared when the next pass begins.
- R6: `detCount` is cleared when a run starts. It grows by one for each lane that becomes newly flagged, and a fault detected again by a later vector in the same pass is not counted twice.
- R7: In the last pass, lanes beyond the remaining faults carry no fault and are never flagged.
- R8: Take the clock edge that accepts `start` as edge k. Each pass takes NUM_VEC+1 cycles. The final flags of pass p are visible after edge k+(p+1)*(NUM_VEC+1). `done` is 0 until it rises together with the flags of the last pass, and then it holds until the next start.
- R9: A `start` pulse while a run is in progress is ignored. It changes neither the results nor the timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a run when idle |
| testVectors | input | NUM_VEC*3 | Test set; vector v at bits [3v+2:3v] |
| faultTable | input | NUM_FAULTS*4 | Faults to inject, 4 bits each |
| laneDet | output | LANES | Per-lane detected flags of the current pass |
| detCount | output | $clog2(NUM_FAULTS+1) | Number of faults detected in this run |
| done | output | 1 | Run finished |

## Verification
A mask loaded into the wrong lane or line shows up as a wrong `laneDet` pattern at the end of that same pass. Such a pattern is never more than NUM_VEC+1 cycles away from the fault. A broken drop rule, or a count that misses increments, makes `detCount` drift from the expected running total at the first pass that re-detects a fault. A wrong pass or vector counter shifts the cycle in which `done` rises, or pairs a fault group with the wrong flags.

// File: rtl/bpfs_pkg.sv
package bpfs_pkg;

  localparam int NUM_PI    = 3;
  localparam int NUM_LINES = 8;
  localparam int NUM_PO    = 2;
  localparam int LINE_W    = $clog2(NUM_LINES);
  localparam int FAULT_W   = LINE_W + 1;

  typedef enum logic [1:0] {GK_PI, GK_AND, GK_OR, GK_NOT} gateKind_e;

  typedef struct packed {
    logic clearCount;
    logic loadMasks;
    logic evalEn;
  } ctlStrobes_t;

  // Levelized netlist: every source index is below the line it feeds.
  function automatic gateKind_e lineKind(input int i);
    case (i)
      0, 1, 2: return GK_PI;
      3, 7:    return GK_AND;
      4:       return GK_NOT;
      default: return GK_OR;
    endcase
  endfunction

  function automatic int lineSrcA(input int i);
    case (i)
      0: return 0;
      1: return 1;
      2: return 2;
      3: return 0;
      4: return 2;
      5: return 3;
      6: return 1;
      default: return 5;
    endcase
  endfunction

  function automatic int lineSrcB(input int i);
    case (i)
      3: return 1;
      5: return 4;
      6: return 2;
      7: return 6;
      default: return 0;
    endcase
  endfunction

  function automatic int poLine(input int k);
    return (k == 0) ? 5 : 7;
  endfunction

endpackage

// File: rtl/bpfs_datapath.sv
module bpfs_datapath
  import bpfs_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int NUM_FAULTS = 16,
  parameter int NUM_VEC    = 8,
  parameter int PASS_W     = 3,
  parameter int VEC_W      = 3,
  parameter int CNT_W      = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  ctlStrobes_t                   ctl,
  input  logic [PASS_W-1:0]             passIdx,
  input  logic [VEC_W-1:0]              vecIdx,
  input  logic [NUM_VEC*NUM_PI-1:0]     testVectors,
  input  logic [NUM_FAULTS*FAULT_W-1:0] faultTable,
  output logic [LANES-1:0]              laneDet,
  output logic [CNT_W-1:0]              detCount
);

  localparam int GROUP = LANES - 1;

  logic [LANES-1:0]   setMask   [NUM_LINES];
  logic [LANES-1:0]   clrMask   [NUM_LINES];
  logic [LANES-1:0]   nextSet   [NUM_LINES];
  logic [LANES-1:0]   nextClr   [NUM_LINES];
  logic [LANES-1:0]   laneValid;
  logic [LANES-1:0]   nextValid;
  logic [FAULT_W-1:0] laneFault [LANES];
  logic [LANES-1:0]   laneOk;

  // Per-lane fault selection for the pass being loaded.
  assign laneFault[0] = '0;
  assign laneOk[0]    = 1'b0;
  for (genvar l = 1; l < LANES; l++) begin : g_lane
    int fIdx;
    assign fIdx      = int'(passIdx) * GROUP + l - 1;
    assign laneOk[l] = (fIdx < NUM_FAULTS);
    assign laneFault[l] = laneOk[l] ? faultTable[fIdx*FAULT_W +: FAULT_W] : '0;
  end

  always_comb begin
    nextValid = laneOk;
    for (int i = 0; i < NUM_LINES; i++) begin
      nextSet[i] = '0;
      nextClr[i] = '0;
    end
    for (int l = 1; l < LANES; l++) begin
      if (laneOk[l] && (int'(laneFault[l][FAULT_W-1:1]) < NUM_LINES)) begin
        nextSet[laneFault[l][FAULT_W-1:1]][l] = laneFault[l][0];
        nextClr[laneFault[l][FAULT_W-1:1]][l] = ~laneFault[l][0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      laneValid <= '0;
      for (int i = 0; i < NUM_LINES; i++) begin
        setMask[i] <= '0;
        clrMask[i] <= '0;
      end
    end else if (ctl.loadMasks) begin
      laneValid <= nextValid;
      for (int i = 0; i < NUM_LINES; i++) begin
        setMask[i] <= nextSet[i];
        clrMask[i] <= nextClr[i];
      end
    end
  end

  // Word-wide evaluation of all lanes in levelized order.
  logic [NUM_PI-1:0] vecBits;
  logic [LANES-1:0]  lineVal [NUM_LINES];

  assign vecBits = testVectors[int'(vecIdx)*NUM_PI +: NUM_PI];

  always_comb begin
    logic [LANES-1:0] raw;
    for (int i = 0; i < NUM_LINES; i++) begin
      case (lineKind(i))
        GK_PI:   raw = {LANES{vecBits[lineSrcA(i)]}};
        GK_AND:  raw = lineVal[lineSrcA(i)] & lineVal[lineSrcB(i)];
        GK_OR:   raw = lineVal[lineSrcA(i)] | lineVal[lineSrcB(i)];
        default: raw = ~lineVal[lineSrcA(i)];
      endcase
      lineVal[i] = (raw & ~clrMask[i]) | setMask[i];
    end
  end

  // Compare every output lane against lane 0.
  logic [LANES-1:0] poDiff;
  logic [LANES-1:0] hit;
  logic [LANES-1:0] newHit;
  logic [CNT_W-1:0] addCnt;

  always_comb begin
    poDiff = '0;
    for (int k = 0; k < NUM_PO; k++) begin
      poDiff = poDiff | (lineVal[poLine(k)] ^ {LANES{lineVal[poLine(k)][0]}});
    end
    hit    = poDiff & laneValid;
    newHit = hit & ~laneDet;
    addCnt = '0;
    for (int l = 0; l < LANES; l++) begin
      addCnt = addCnt + CNT_W'(newHit[l]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      laneDet  <= '0;
      detCount <= '0;
    end else begin
      if (ctl.loadMasks)   laneDet <= '0;
      else if (ctl.evalEn) laneDet <= laneDet | hit;
      if (ctl.clearCount)  detCount <= '0;
      else if (ctl.evalEn) detCount <= detCount + addCnt;
    end
  end

endmodule

// File: rtl/bpfs_control.sv
module bpfs_control
  import bpfs_pkg::*;
#(
  parameter int NUM_PASSES = 6,
  parameter int NUM_VEC    = 8,
  parameter int PASS_W     = 3,
  parameter int VEC_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output ctlStrobes_t       ctl,
  output logic [PASS_W-1:0] passIdx,
  output logic [VEC_W-1:0]  vecIdx,
  output logic              done
);

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_EVAL} state_e;
  state_e state;

  logic lastVec;
  logic lastPass;
  assign lastVec  = (vecIdx == VEC_W'(NUM_VEC - 1));
  assign lastPass = (passIdx == PASS_W'(NUM_PASSES - 1));

  always_comb begin
    ctl            = '0;
    ctl.clearCount = (state == ST_IDLE) && start;
    ctl.loadMasks  = (state == ST_LOAD);
    ctl.evalEn     = (state == ST_EVAL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      passIdx <= '0;
      vecIdx  <= '0;
      done    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_LOAD;
            passIdx <= '0;
            done    <= 1'b0;
          end
        end
        ST_LOAD: begin
          state  <= ST_EVAL;
          vecIdx <= '0;
        end
        default: begin
          if (lastVec) begin
            if (lastPass) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end else begin
              state   <= ST_LOAD;
              passIdx <= passIdx + 1'b1;
            end
          end else begin
            vecIdx <= vecIdx + 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/bitpar_fault_sim.sv
module bitpar_fault_sim
  import bpfs_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int NUM_FAULTS = 16,
  parameter int NUM_VEC    = 8
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   start,
  input  logic [NUM_VEC*NUM_PI-1:0]              testVectors,
  input  logic [NUM_FAULTS*FAULT_W-1:0]          faultTable,
  output logic [LANES-1:0]                       laneDet,
  output logic [$clog2(NUM_FAULTS+1)-1:0]        detCount,
  output logic                                   done
);

  localparam int NUM_PASSES = (NUM_FAULTS + LANES - 2) / (LANES - 1);
  localparam int PASS_W     = (NUM_PASSES > 1) ? $clog2(NUM_PASSES) : 1;
  localparam int VEC_W      = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;
  localparam int CNT_W      = $clog2(NUM_FAULTS + 1);

  ctlStrobes_t       ctl;
  logic [PASS_W-1:0] passIdx;
  logic [VEC_W-1:0]  vecIdx;

  bpfs_control #(
    .NUM_PASSES(NUM_PASSES), .NUM_VEC(NUM_VEC), .PASS_W(PASS_W), .VEC_W(VEC_W)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .ctl(ctl),
    .passIdx(passIdx), .vecIdx(vecIdx), .done(done)
  );

  bpfs_datapath #(
    .LANES(LANES), .NUM_FAULTS(NUM_FAULTS), .NUM_VEC(NUM_VEC),
    .PASS_W(PASS_W), .VEC_W(VEC_W), .CNT_W(CNT_W)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .passIdx(passIdx), .vecIdx(vecIdx),
    .testVectors(testVectors), .faultTable(faultTable),
    .laneDet(laneDet), .detCount(detCount)
  );

endmodule

// File: rtl/bitpar_fault_sim_chk.sv
module bitpar_fault_sim_chk
  import bpfs_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int NUM_FAULTS = 16,
  parameter int CNT_W      = 5
) (
  input logic             clk,
  input logic             rst_n,
  input ctlStrobes_t      ctl,
  input logic [LANES-1:0] laneDet,
  input logic [CNT_W-1:0] detCount,
  input logic             done
);

  localparam int NUM_PASSES = (NUM_FAULTS + LANES - 2) / (LANES - 1);
  localparam int LAST_USED  = NUM_FAULTS - (NUM_PASSES - 1) * (LANES - 1);
  localparam logic [LANES-1:0] UNUSED_MASK = LANES'({LANES{1'b1}} << (LAST_USED + 1));

  // R2: the reference lane is never reported
  a_r2_lane0_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    laneDet[0] == 1'b0);

  // R5: flags only accumulate during evaluation
  a_r5_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.evalEn |=> (($past(laneDet) & ~laneDet) == '0));

  // R6: count grows by exactly the newly raised flags
  a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.evalEn |=> (int'(detCount) == int'($past(detCount))
                    + $countones(laneDet) - $countones($past(laneDet))));

  // R7: empty lanes of the last pass stay clear
  a_r7_unused_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((laneDet & UNUSED_MASK) == '0));

  // R8: no pass activity once finished
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(ctl.loadMasks || ctl.evalEn));

  // R9: control issues one strobe at a time
  a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl.clearCount, ctl.loadMasks, ctl.evalEn}));

endmodule

bind bitpar_fault_sim bitpar_fault_sim_chk #(
  .LANES(LANES), .NUM_FAULTS(NUM_FAULTS), .CNT_W($clog2(NUM_FAULTS+1))
) chk_i (
  .clk(clk), .rst_n(rst_n), .ctl(ctl),
  .laneDet(laneDet), .detCount(detCount), .done(done)
);

// File: tb/bitpar_fault_sim_tb_top.sv
`timescale 1ns/1ps
module bitpar_fault_sim_tb_top;

  localparam int LANES  = 4;
  localparam int NF     = 16;
  localparam int NV     = 8;
  localparam int GROUP  = LANES - 1;
  localparam int PASSES = (NF + GROUP - 1) / GROUP;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [NV*3-1:0] testVectors = '0;
  logic [NF*4-1:0] faultTable = '0;
  logic [LANES-1:0] laneDet;
  logic [4:0]       detCount;
  logic             done;

  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  bitpar_fault_sim #(.LANES(LANES), .NUM_FAULTS(NF), .NUM_VEC(NV)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .testVectors(testVectors),
    .faultTable(faultTable), .laneDet(laneDet), .detCount(detCount), .done(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Netlist outputs {line7, line5} with an optional stuck line.
  function automatic logic [1:0] netOut(input logic [2:0] v, input int fl,
                                        input logic fv, input bit en);
    logic [7:0] n;
    for (int i = 0; i < 8; i++) begin
      case (i)
        0, 1, 2: n[i] = v[i];
        3: n[i] = n[0] & n[1];
        4: n[i] = ~n[2];
        5: n[i] = n[3] | n[4];
        6: n[i] = n[1] | n[2];
        default: n[i] = n[5] & n[6];
      endcase
      if (en && fl == i) n[i] = fv;
    end
    return {n[7], n[5]};
  endfunction

  function automatic bit detects(input int f);
    logic [3:0] e;
    e = faultTable[f*4 +: 4];
    for (int v = 0; v < NV; v++) begin
      logic [2:0] tv;
      tv = testVectors[v*3 +: 3];
      if (netOut(tv, 0, 1'b0, 1'b0) != netOut(tv, int'(e[3:1]), e[0], 1'b1)) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic runCase(input string tag, input bit midStart);
    int expCount;
    expCount = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int p = 0; p < PASSES; p++) begin
      logic [LANES-1:0] expDet;
      expDet = '0;
      for (int l = 1; l < LANES; l++) begin
        int f;
        f = p * GROUP + l - 1;
        if (f < NF && detects(f)) expDet[l] = 1'b1;
      end
      expCount += $countones(expDet);
      if (midStart && p == 1) begin
        start = 1'b1;               // R9: ignored while running
        @(posedge clk);
        #1 start = 1'b0;
        repeat (NV) @(posedge clk);
      end else begin
        repeat (NV + 1) @(posedge clk);
      end
      @(negedge clk);
      check($sformatf("R5 %s pass %0d laneDet", tag, p), 32'(laneDet), 32'(expDet));
      check($sformatf("R6 %s pass %0d detCount", tag, p), 32'(detCount), 32'(expCount));
      check($sformatf("R8 %s pass %0d done", tag, p), 32'(done), 32'(p == PASSES - 1));
    end
    repeat (5) @(negedge clk);
    check($sformatf("R8 %s done held", tag), 32'(done), 32'd1);
    check($sformatf("R6 %s count held", tag), 32'(detCount), 32'(expCount));
  endtask

  initial begin
    repeat (1000 * NV * PASSES) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 laneDet reset", 32'(laneDet), 32'd0);
    check("R1 detCount reset", 32'(detCount), 32'd0);
    check("R1 done reset", 32'(done), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R4: natural fault order, exhaustive vectors
    for (int f = 0; f < NF; f++) faultTable[f*4 +: 4] = {3'(f >> 1), 1'(f & 1)};
    for (int v = 0; v < NV; v++) testVectors[v*3 +: 3] = 3'(v);
    runCase("exhaustive", 1'b0);

    // R7: a single repeated vector leaves faults undetected
    for (int v = 0; v < NV; v++) testVectors[v*3 +: 3] = 3'd0;
    runCase("constant", 1'b0);

    // R9: reversed table, scrambled vectors, stray start
    for (int f = 0; f < NF; f++) faultTable[f*4 +: 4] = {3'((NF-1-f) >> 1), 1'((NF-1-f) & 1)};
    for (int v = 0; v < NV; v++) testVectors[v*3 +: 3] = 3'((v * 5 + 3) % 8);
    runCase("scrambled", 1'b1);

    // R3: duplicated faults on the gate lines
    for (int f = 0; f < NF; f++) faultTable[f*4 +: 4] = {3'((f % 4) + 4), 1'((f / 4) & 1)};
    for (int v = 0; v < NV; v++) testVectors[v*3 +: 3] = (v < 4) ? 3'd7 : 3'(v);
    runCase("duplicate", 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end

endmodule